// File: doc/BRIEF.md
# Converter Result and Interrupt Register Bank

This block is the register bank that sits between a multi-channel analog-to-digital converter sequencer and the processor bus. The sequencer reports each finished conversion as a one-cycle completion event that carries the channel number and a 10-bit result. The bank keeps one result register per channel and a register that holds the most recent result from any channel. It also keeps a set of read-sensitive status flags and an interrupt mask, and it drives one interrupt line.

The bus port is a simple single-cycle interface. A write takes effect at the clock edge where `bus_sel` and `bus_we` are high. Read data is driven combinationally from `bus_addr` within the same cycle. The side effects of a read, which clear flags, take effect at the edge that ends that cycle. Channel enables are changed through separate set-only and clear-only registers, and the interrupt mask works the same way. This lets software change single bits without a read-modify-write sequence.

Top module: `adc_regbank`

## Requirements
- R1: Writing a 1 to a bit at offset 0x10 enables that channel, and writing a 1 to a bit at offset 0x14 disables it. Writing 0 bits changes nothing. Offset 0x18 reads the current enables in bits 7:0.
- R2: The status word at offset 0x1C has the end-of-conversion flags in bits 7:0, the per-channel overrun flags in bits 15:8, data-ready in bit 16 and general overrun in bit 17. All other bits read 0. An end-of-conversion bit reads 1 only while its channel is enabled and a result for it has completed and not been read.
- R3: A completion for an enabled channel loads its result into that channel's register (offset 0x30 + 4·channel, bits 9:0) and sets its end-of-conversion flag. A completion for a disabled channel leaves that channel's register and flag unchanged.
- R4: Every completion, from an enabled or a disabled channel, loads its result into the last-result register (offset 0x20, bits 9:0) and sets data-ready. All result registers hold their values until a newer result arrives. After reset every result register reads 0.
- R5: Reading a channel's result register clears that channel's end-of-conversion flag.
- R6: A channel's overrun flag is set when a completion for that enabled channel arrives while its end-of-conversion flag is still 1. Reading the status word clears all the overrun flags.
- R7: General overrun is set when any completion arrives while data-ready is still 1. Reading the last-result register clears both data-ready and general overrun.
- R8: When a completion and a clearing read hit the same flag in the same cycle, the flag ends up set.
- R9: Writing a 1 to a bit at offset 0x24 sets that mask bit, and writing a 1 to a bit at offset 0x28 clears it. Writing 0 bits has no effect. Offset 0x2C reads the mask, which uses the same bit layout as the status word.
- R10: `irq` is high exactly when some status bit and its mask bit are both 1.
- R11: Offsets not listed above, including 0x00 and 0x04, read as 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| done_valid | input | 1 | Completion event from the sequencer |
| done_chan | input | 3 | Channel of the completion |
| done_data | input | 10 | Result of the completion |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `done_chan` is always a valid channel number and that there is at most one bus access per cycle. The overrun and general-overrun checks only hold if flags change at clock edges after reset, never between edges. The stimulus drives every input on the falling edge and holds it for one full cycle. It never changes an enable in the same cycle as a completion, so the channel enable that gates a completion is always the registered one. Completions and clearing reads are placed in the same cycle on purpose, but only in the cases that R8 names.

// File: rtl/adc_rb_pkg.sv
package adc_rb_pkg;

    // Register offsets (byte addresses)
    localparam logic [7:0] OFS_CHEN   = 8'h10;
    localparam logic [7:0] OFS_CHDIS  = 8'h14;
    localparam logic [7:0] OFS_CHSTAT = 8'h18;
    localparam logic [7:0] OFS_STAT   = 8'h1C;
    localparam logic [7:0] OFS_LAST   = 8'h20;
    localparam logic [7:0] OFS_IEN    = 8'h24;
    localparam logic [7:0] OFS_IDIS   = 8'h28;
    localparam logic [7:0] OFS_IMASK  = 8'h2C;
    localparam logic [7:0] OFS_DATA0  = 8'h30;
    localparam int         DATA_STEP  = 4;

endpackage

// File: rtl/adc_rb_data.sv
module adc_rb_data #(
    parameter int NCH = 8,
    parameter int DW  = 10,
    localparam int CW = $clog2(NCH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCH-1:0]           chan_en,
    input  logic                     done_valid,
    input  logic [CW-1:0]            done_chan,
    input  logic [DW-1:0]            done_data,
    output logic [NCH-1:0][DW-1:0]   cdr,
    output logic [DW-1:0]            last
);

    typedef struct packed {
        logic [NCH-1:0][DW-1:0] cdr;
        logic [DW-1:0]          last;
    } data_t;

    data_t d, q;

    always_comb begin
        d = q;
        if (done_valid) begin
            d.last = done_data;
        end
        for (int i = 0; i < NCH; i++) begin
            if (done_valid && done_chan == CW'(i) && chan_en[i]) begin
                d.cdr[i] = done_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cdr  = q.cdr;
    assign last = q.last;

    // R4: every completion lands in the last-result register
    p_last_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (q.last == $past(done_data)));

    // R3: a channel register only moves on a completion for that enabled channel
    for (genvar i = 0; i < NCH; i++) begin : g_chk
        p_cdr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !(done_valid && done_chan == CW'(i) && chan_en[i]) |=> $stable(q.cdr[i]));
    end

endmodule

// File: rtl/adc_rb_flags.sv
module adc_rb_flags #(
    parameter int NCH = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] chan_en,
    input  logic           done_valid,
    input  logic [CW-1:0]  done_chan,
    input  logic           rd_stat,
    input  logic           rd_last,
    input  logic [NCH-1:0] rd_data_hit,
    output logic [NCH-1:0] eoc,
    output logic [NCH-1:0] ovr,
    output logic           drdy,
    output logic           govre
);

    typedef struct packed {
        logic [NCH-1:0] eoc;
        logic [NCH-1:0] ovr;
        logic           drdy;
        logic           govre;
    } flags_t;

    flags_t d, q;
    logic [NCH-1:0] hit;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            hit[i] = done_valid && (done_chan == CW'(i)) && chan_en[i];
        end
        d       = q;
        // clears first, sets afterwards: a same-cycle event wins
        d.eoc   = (q.eoc & ~rd_data_hit) | hit;
        d.ovr   = (rd_stat ? '0 : q.ovr) | (hit & q.eoc);
        d.drdy  = done_valid | (q.drdy & ~rd_last);
        d.govre = (done_valid & q.drdy) | (q.govre & ~rd_last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign eoc   = q.eoc;
    assign ovr   = q.ovr;
    assign drdy  = q.drdy;
    assign govre = q.govre;

    // R8: a completion always leaves data-ready set, even against a clearing read
    p_drdy_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> q.drdy);

    // R7: general overrun needs an unread result in the cycle before
    p_govre_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.govre) |-> $past(q.drdy));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R6: channel overrun needs that channel's flag already set
        p_ovr_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(q.ovr[i]) |-> $past(q.eoc[i]));
    end

endmodule

// File: rtl/adc_regbank.sv
module adc_regbank #(
    parameter int NCH = 8,
    parameter int DW  = 10,
    parameter int AW  = 8,
    parameter int BW  = 32,
    localparam int CW = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata,
    input  logic          done_valid,
    input  logic [CW-1:0] done_chan,
    input  logic [DW-1:0] done_data,
    output logic          irq
);

    import adc_rb_pkg::*;

    localparam int FW = 2 * NCH + 2;

    typedef struct packed {
        logic [NCH-1:0] en;
        logic [FW-1:0]  mask;
    } cfg_t;

    cfg_t d, q;

    logic                   wr, rd, rd_stat, rd_last;
    logic [NCH-1:0]         rd_data_hit;
    logic [NCH-1:0]         eoc, ovr;
    logic                   drdy, govre;
    logic [NCH-1:0][DW-1:0] cdr;
    logic [DW-1:0]          last;
    logic [FW-1:0]          status;
    logic                   unused_wdata;

    assign unused_wdata = ^bus_wdata[BW-1:FW];

    assign wr      = bus_sel & bus_we;
    assign rd      = bus_sel & ~bus_we;
    assign rd_stat = rd && (bus_addr == AW'(OFS_STAT));
    assign rd_last = rd && (bus_addr == AW'(OFS_LAST));

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            rd_data_hit[i] = rd && (bus_addr == AW'(OFS_DATA0 + DATA_STEP * i));
        end
    end

    always_comb begin
        d = q;
        if (wr) begin
            case (bus_addr)
                AW'(OFS_CHEN):  d.en   = q.en | bus_wdata[NCH-1:0];
                AW'(OFS_CHDIS): d.en   = q.en & ~bus_wdata[NCH-1:0];
                AW'(OFS_IEN):   d.mask = q.mask | bus_wdata[FW-1:0];
                AW'(OFS_IDIS):  d.mask = q.mask & ~bus_wdata[FW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    adc_rb_flags #(.NCH(NCH)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_en     (q.en),
        .done_valid  (done_valid),
        .done_chan   (done_chan),
        .rd_stat     (rd_stat),
        .rd_last     (rd_last),
        .rd_data_hit (rd_data_hit),
        .eoc         (eoc),
        .ovr         (ovr),
        .drdy        (drdy),
        .govre       (govre)
    );

    adc_rb_data #(.NCH(NCH), .DW(DW)) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_en    (q.en),
        .done_valid (done_valid),
        .done_chan  (done_chan),
        .done_data  (done_data),
        .cdr        (cdr),
        .last       (last)
    );

    assign status = {govre, drdy, ovr, eoc & q.en};
    assign irq    = |(status & q.mask);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(OFS_CHSTAT): bus_rdata = BW'(q.en);
            AW'(OFS_STAT):   bus_rdata = BW'(status);
            AW'(OFS_LAST):   bus_rdata = BW'(last);
            AW'(OFS_IMASK):  bus_rdata = BW'(q.mask);
            default: ;
        endcase
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == AW'(OFS_DATA0 + DATA_STEP * i)) begin
                bus_rdata = BW'(cdr[i]);
            end
        end
    end

    // R9: a 1 written to the set-mask offset shows up in the mask
    p_mask_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == AW'(OFS_IEN)) |=>
            ((q.mask & $past(bus_wdata[FW-1:0])) == $past(bus_wdata[FW-1:0])));

    // R9: a 1 written to the clear-mask offset removes the bit
    p_mask_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == AW'(OFS_IDIS)) |=>
            ((q.mask & $past(bus_wdata[FW-1:0])) == '0));

    // R1: a 1 written to the disable offset turns the channel off
    p_chen_clr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == AW'(OFS_CHDIS)) |=>
            ((q.en & $past(bus_wdata[NCH-1:0])) == '0));

    // R11: accesses that are not writes leave the configuration alone
    p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(q));

endmodule

// File: tb/adc_regbank_test.sv
module adc_regbank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        done_valid = 1'b0;
    logic [2:0]  done_chan = '0;
    logic [9:0]  done_data = '0;
    logic        irq;

    always #4 clk = ~clk;   // 125 MHz

    adc_regbank uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .done_valid(done_valid), .done_chan(done_chan), .done_data(done_data),
        .irq(irq)
    );

    int checks = 0, fails = 0;
    bit finished = 0;

    // reference state, derived from the requirements
    logic [7:0]  m_en = '0, m_eoc = '0, m_ovr = '0;
    logic        m_drdy = 0, m_govre = 0;
    logic [17:0] m_mask = '0;
    logic [9:0]  m_cdr [8];
    logic [9:0]  m_last = '0;

    function automatic logic [17:0] m_status();
        return {m_govre, m_drdy, m_ovr, m_eoc & m_en};
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        if (a >= 8'h30 && a <= 8'h4C && a[1:0] == 2'b00) return 32'(m_cdr[(a - 8'h30) >> 2]);
        case (a)
            8'h18: return 32'(m_en);
            8'h1C: return 32'(m_status());
            8'h20: return 32'(m_last);
            8'h2C: return 32'(m_mask);
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic sel, input logic we, input logic [7:0] a,
                        input logic [31:0] wd, input logic dv, input logic [2:0] dc,
                        input logic [9:0] dd, output logic [31:0] rdv, output logic irqv);
        logic [7:0] old_eoc;
        logic       old_drdy;
        @(negedge clk);
        bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = wd;
        done_valid = dv; done_chan = dc; done_data = dd;
        #2;
        rdv = bus_rdata; irqv = irq;
        @(posedge clk);
        old_eoc = m_eoc; old_drdy = m_drdy;
        if (sel && we) begin
            case (a)
                8'h10: m_en   = m_en | wd[7:0];
                8'h14: m_en   = m_en & ~wd[7:0];
                8'h24: m_mask = m_mask | wd[17:0];
                8'h28: m_mask = m_mask & ~wd[17:0];
                default: ;
            endcase
        end
        if (sel && !we) begin
            if (a == 8'h1C) m_ovr = '0;
            if (a == 8'h20) begin m_drdy = 0; m_govre = 0; end
            if (a >= 8'h30 && a <= 8'h4C && a[1:0] == 2'b00) m_eoc[(a - 8'h30) >> 2] = 1'b0;
        end
        if (dv) begin
            m_last  = dd;
            m_govre = m_govre | old_drdy;
            m_drdy  = 1'b1;
            if (m_en[dc]) begin
                m_ovr[dc] = m_ovr[dc] | old_eoc[dc];
                m_eoc[dc] = 1'b1;
                m_cdr[dc] = dd;
            end
        end
        #1;
        bus_sel = 0; bus_we = 0; done_valid = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] r; logic i;
        step(1, 1, a, d, 0, 0, 0, r, i);
    endtask

    task automatic rd_chk(input logic [7:0] a, input string req);
        logic [31:0] r, e; logic i, ei;
        e = m_read(a); ei = |(m_status() & m_mask);
        step(1, 0, a, 0, 0, 0, 0, r, i);
        check(req, r, e);
        check({req, " irq (R10)"}, 32'(i), 32'(ei));
    endtask

    task automatic conv(input logic [2:0] c, input logic [9:0] d);
        logic [31:0] r; logic i;
        step(0, 0, 0, 0, 1, c, d, r, i);
    endtask

    task automatic conv_rd(input logic [2:0] c, input logic [9:0] d, input logic [7:0] a, input string req);
        logic [31:0] r, e; logic i;
        e = m_read(a);
        step(1, 0, a, 0, 1, c, d, r, i);
        check(req, r, e);
    endtask

    initial begin
        #(8 * 190000);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) m_cdr[k] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state
        rd_chk(8'h1C, "R2 reset status");
        rd_chk(8'h18, "R1 reset enables");
        rd_chk(8'h20, "R4 reset last");
        rd_chk(8'h2C, "R9 reset mask");
        for (int k = 0; k < 8; k++) rd_chk(8'(8'h30 + 4 * k), "R4 reset channel data");

        // R1: every enable pattern, with zero writes in between
        for (int p = 0; p < 256; p++) begin
            wr(8'h10, 32'(p));
            wr(8'h14, 32'(~p & 8'hFF));
            wr(8'h10, 32'h0);
            wr(8'h14, 32'h0);
            rd_chk(8'h18, "R1 enable set/clear");
        end

        // R11: unmapped offsets
        foreach (m_cdr[k]) ; 
        wr(8'h00, 32'hFFFF_FFFF); rd_chk(8'h00, "R11 offset 0x00");
        wr(8'h04, 32'hFFFF_FFFF); rd_chk(8'h04, "R11 offset 0x04");
        wr(8'h50, 32'hFFFF_FFFF); rd_chk(8'h50, "R11 offset 0x50");
        rd_chk(8'h18, "R11 enables untouched");
        rd_chk(8'h2C, "R11 mask untouched");

        // R9: mask set/clear sweep over single bits
        for (int b = 0; b < 18; b++) begin
            wr(8'h24, 32'(1) << b);
            rd_chk(8'h2C, "R9 mask set");
        end
        wr(8'h28, 32'h0002_AAAA); rd_chk(8'h2C, "R9 mask clear");
        wr(8'h28, 32'h0); rd_chk(8'h2C, "R9 mask zero write");
        wr(8'h28, 32'h3_FFFF); rd_chk(8'h2C, "R9 mask cleared");

        // R3/R4/R5: conversions on every channel with half the channels enabled
        wr(8'h14, 32'hFF); wr(8'h10, 32'h5A);
        for (int c = 0; c < 8; c++) begin
            conv(3'(c), 10'((c * 97 + 13) & 10'h3FF));
            rd_chk(8'h1C, "R2 status after completion");
            rd_chk(8'h20, "R4 last result");
            rd_chk(8'h20, "R7 data-ready cleared");
            rd_chk(8'(8'h30 + 4 * c), "R3 channel data");
            rd_chk(8'h1C, "R5 end-of-conversion cleared");
        end
        for (int k = 0; k < 8; k++) rd_chk(8'(8'h30 + 4 * k), "R3 disabled channels hold");

        // R6/R7: overruns
        for (int c = 0; c < 8; c++) begin
            conv(3'(c), 10'(c + 100));
            conv(3'(c), 10'(c + 200));
            rd_chk(8'h1C, "R6 overrun flagged");
            rd_chk(8'h1C, "R6 overrun cleared by status read");
            rd_chk(8'h20, "R7 general overrun");
            rd_chk(8'h1C, "R7 cleared by last read");
            rd_chk(8'(8'h30 + 4 * c), "R4 newest result held");
        end

        // R2: disabling a channel hides its pending flag
        conv(3'd1, 10'h155);
        wr(8'h14, 32'h02);
        rd_chk(8'h1C, "R2 flag hidden when disabled");
        wr(8'h10, 32'h02);
        rd_chk(8'h1C, "R2 flag visible again");

        // R8: same-cycle set and clear
        conv_rd(3'd1, 10'h2AA, 8'h1C, "R8 status read with overrun");
        rd_chk(8'h1C, "R8 overrun survives status read");
        conv_rd(3'd3, 10'h0F0, 8'h20, "R8 last read with completion");
        rd_chk(8'h1C, "R8 data-ready survives last read");
        conv(3'd4, 10'h011);
        conv_rd(3'd4, 10'h022, 8'h40, "R8 channel read with completion");
        rd_chk(8'h1C, "R8 end-of-conversion survives channel read");
        rd_chk(8'h40, "R8 newest channel data");

        // R10: every mask bit alone, in two status states
        for (int s = 0; s < 2; s++) begin
            if (s == 1) begin rd_chk(8'h20, "R7 clear"); rd_chk(8'h1C, "R6 clear"); end
            for (int b = 0; b < 18; b++) begin
                wr(8'h28, 32'h3_FFFF);
                wr(8'h24, 32'(1) << b);
                rd_chk(8'h18, "R10 single mask bit");
            end
        end
        wr(8'h24, 32'h3_FFFF);
        rd_chk(8'h18, "R10 full mask");

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule